// File: doc/BRIEF.md
# IOMMU Translation Cache with Selective Invalidation

This block is a small, fully associative store of finished DMA address translations. It sits beside an IOMMU's page walker. Each incoming request first probes the cache with its requester source ID and target address. On a hit, the cache returns the cached leaf page-table entry, the read and write permission bits and the translated address in the same cycle, so no walk is needed. On a miss, the walker resolves the translation and writes it back through the fill port, together with the domain the requester belongs to.

Entries are keyed by source ID and 4 KiB frame number, but software removes them by domain. The invalidate port accepts three kinds of command: clear everything, clear every entry of one domain, or clear the entries of one domain whose frame falls inside a naturally aligned group of 2^am frames. A clear-everything command takes one cycle. The two selective kinds visit the slots one per cycle. A controller with three states runs each command. In IDLE it accepts a command. A global or rejected command goes from IDLE to FINISH. A domain or page command goes from IDLE to SWEEP. SWEEP moves on to FINISH after the last slot. FINISH always returns to IDLE and raises the done pulse. The block has no eviction policy. When a fill needs a new slot and every slot is occupied, the whole cache is emptied first.

Top module: `xlat_cache`

## Requirements
- R1: After reset no slot is occupied: every lookup misses, and `busy` and `inv_done` are low.
- R2: A lookup is answered combinationally in the cycle it is presented. On a hit, `lk_pte`, `lk_rd` and `lk_wr` return the stored values, and `lk_phys` is the entry's address bits [ADDR_W-1:12] followed by `lk_addr[11:0]`. A miss drives `lk_hit` low.
- R3: The match key is the frame number `addr >> 12` bitwise-ORed with the source ID shifted left by 36. The same frame under two different source IDs gives two independent entries.
- R4: A fill whose key equals that of an occupied slot overwrites that slot in place. It takes no second slot, so capacity is unchanged.
- R5: A fill of a new key while all ENTRIES slots are occupied empties the cache and then stores the new entry. It is the only entry present afterwards.
- R6: An invalidate with `inv_kind` = 2'b01 (global) empties the cache. `inv_done` is high in the first cycle after the command is accepted.
- R7: An invalidate with `inv_kind` = 2'b10 (domain) removes exactly the entries whose domain equals `inv_did`. It visits one slot per cycle, and `inv_done` is high in cycle ENTRIES+1 after acceptance.
- R8: An invalidate with `inv_kind` = 2'b11 (page) and mask value am (0 to 9) removes exactly the entries that meet two conditions: the domain equals `inv_did`, and `frame >> am` equals `(inv_addr >> 12) >> am`. Its timing is that of R7.
- R9: A command with `inv_kind` = 2'b00, or a page command with am greater than 9, changes no entry. It raises `inv_done` together with `inv_err` in the first cycle after acceptance.
- R10: While `busy` is high, lookups miss, and fills and new invalidate commands are ignored.
- R11: When an invalidate and a fill are presented together while idle, the invalidate is accepted and the fill is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_sid | input | SID_W | Lookup source ID |
| lk_addr | input | ADDR_W | Lookup input address |
| lk_hit | output | 1 | Lookup found a cached translation |
| lk_pte | output | PTE_W | Cached leaf page-table entry (zero on miss) |
| lk_rd | output | 1 | Read permitted (zero on miss) |
| lk_wr | output | 1 | Write permitted (zero on miss) |
| lk_phys | output | ADDR_W | Translated address (zero on miss) |
| fl_valid | input | 1 | Fill request |
| fl_sid | input | SID_W | Fill source ID |
| fl_did | input | DID_W | Fill domain ID |
| fl_addr | input | ADDR_W | Fill input address |
| fl_pte | input | PTE_W | Fill leaf page-table entry |
| fl_rd | input | 1 | Fill read permission |
| fl_wr | input | 1 | Fill write permission |
| inv_valid | input | 1 | Invalidate command |
| inv_kind | input | 2 | 01 global, 10 domain, 11 page, 00 rejected |
| inv_did | input | DID_W | Domain for selective commands |
| inv_addr | input | ADDR_W | Address for the page command |
| inv_am | input | AM_W | Address-mask value for the page command |
| busy | output | 1 | Controller not in IDLE |
| inv_done | output | 1 | One-cycle end-of-command pulse |
| inv_err | output | 1 | Command rejected, valid with inv_done |

## Verification
A corrupted occupancy bit, a wrong key, or a stale domain shows up at the next lookup of that key. The lookup path has no register, so it appears as a hit where a miss is due, or the reverse, in the very cycle the key is probed. The bench sweeps every mask value from 0 to 9. At each value it places entries just inside and just outside the aligned group and in a foreign domain, so a mask that is off by one bit leaves a wrong hit or miss that the following probes catch. Controller faults are exposed by counting cycles from acceptance to `inv_done`, and by probing lookups and fills while `busy` is high.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int PAGE_SHIFT = 12;
    localparam int SID_SHIFT  = 36;
    localparam int MAX_AM     = 9;

    typedef enum logic [1:0] {
        INV_NONE = 2'b00,
        INV_ALL  = 2'b01,
        INV_DOM  = 2'b10,
        INV_PAGE = 2'b11
    } inv_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SWEEP,
        ST_FINISH
    } ctrl_state_e;

endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
    parameter int N       = 16,
    parameter int TAG_W   = 52,
    parameter int FRAME_W = 36,
    parameter int DID_W   = 16
) (
    input  logic [N-1:0]       valid_q,
    input  logic [TAG_W-1:0]   tag_q   [N],
    input  logic [FRAME_W-1:0] frame_q [N],
    input  logic [DID_W-1:0]   did_q   [N],
    input  logic [TAG_W-1:0]   lk_tag,
    input  logic [TAG_W-1:0]   fl_tag,
    input  logic               cmd_page,
    input  logic [DID_W-1:0]   cmd_did,
    input  logic [FRAME_W-1:0] cmd_frame,
    input  logic [FRAME_W-1:0] cmd_mask,
    output logic [N-1:0]       lk_vec,
    output logic [N-1:0]       fl_vec,
    output logic [N-1:0]       inv_vec
);

    for (genvar i = 0; i < N; i++) begin : g_slot
        logic dom_eq;
        logic frm_eq;
        assign dom_eq     = (did_q[i] == cmd_did);
        assign frm_eq     = ((frame_q[i] & cmd_mask) == (cmd_frame & cmd_mask));
        assign lk_vec[i]  = valid_q[i] && (tag_q[i] == lk_tag);
        assign fl_vec[i]  = valid_q[i] && (tag_q[i] == fl_tag);
        assign inv_vec[i] = valid_q[i] && dom_eq && (!cmd_page || frm_eq);
    end

endmodule

// File: rtl/xlat_slot_pick.sv
module xlat_slot_pick #(
    parameter  int N     = 16,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     valid_q,
    input  logic [N-1:0]     fl_vec,
    output logic [IDX_W-1:0] slot,
    output logic             flush
);

    logic found;

    always_comb begin
        slot  = '0;
        flush = 1'b0;
        found = 1'b0;
        if (|fl_vec) begin
            for (int i = 0; i < N; i++) begin
                if (!found && fl_vec[i]) begin
                    slot  = IDX_W'(i);
                    found = 1'b1;
                end
            end
        end else if (&valid_q) begin
            flush = 1'b1;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (!found && !valid_q[i]) begin
                    slot  = IDX_W'(i);
                    found = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/xlat_inv_ctrl.sv
module xlat_inv_ctrl
    import xlat_pkg::*;
#(
    parameter  int N       = 16,
    parameter  int FRAME_W = 36,
    parameter  int DID_W   = 16,
    parameter  int AM_W    = 6,
    localparam int IDX_W   = (N > 1) ? $clog2(N) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               inv_valid,
    input  logic [1:0]         inv_kind,
    input  logic [DID_W-1:0]   inv_did,
    input  logic [FRAME_W-1:0] inv_frame,
    input  logic [AM_W-1:0]    inv_am,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic               accept,
    output logic               clear_all,
    output logic               sweep_en,
    output logic [IDX_W-1:0]   sweep_idx,
    output logic               cmd_page,
    output logic [DID_W-1:0]   cmd_did,
    output logic [FRAME_W-1:0] cmd_frame,
    output logic [FRAME_W-1:0] cmd_mask
);

    ctrl_state_e        state_q, state_d;
    logic [IDX_W-1:0]   idx_q;
    logic               err_q;
    logic               page_q;
    logic [DID_W-1:0]   did_q;
    logic [FRAME_W-1:0] frame_q;
    logic [FRAME_W-1:0] mask_q;
    logic               bad;
    logic               is_all;

    always_comb begin
        accept  = inv_valid && (state_q == ST_IDLE);
        bad     = (inv_kind == INV_NONE) ||
                  ((inv_kind == INV_PAGE) && (inv_am > AM_W'(MAX_AM)));
        is_all  = (inv_kind == INV_ALL);
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = (bad || is_all) ? ST_FINISH : ST_SWEEP;
                end
            end
            ST_SWEEP: begin
                if (idx_q == IDX_W'(N - 1)) begin
                    state_d = ST_FINISH;
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            err_q   <= 1'b0;
            page_q  <= 1'b0;
            did_q   <= '0;
            frame_q <= '0;
            mask_q  <= '0;
        end else if (accept) begin
            idx_q   <= '0;
            err_q   <= bad;
            page_q  <= (inv_kind == INV_PAGE);
            did_q   <= inv_did;
            frame_q <= inv_frame;
            mask_q  <= {FRAME_W{1'b1}} << inv_am;
        end else if (state_q == ST_SWEEP) begin
            idx_q <= idx_q + IDX_W'(1);
        end
    end

    always_comb begin
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_FINISH);
        err       = (state_q == ST_FINISH) && err_q;
        clear_all = accept && is_all && !bad;
        sweep_en  = (state_q == ST_SWEEP);
        sweep_idx = idx_q;
        cmd_page  = page_q;
        cmd_did   = did_q;
        cmd_frame = frame_q;
        cmd_mask  = mask_q;
    end

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int ADDR_W  = 48,
    parameter int SID_W   = 16,
    parameter int DID_W   = 16,
    parameter int PTE_W   = 64,
    parameter int AM_W    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [SID_W-1:0]  lk_sid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic [PTE_W-1:0]  lk_pte,
    output logic              lk_rd,
    output logic              lk_wr,
    output logic [ADDR_W-1:0] lk_phys,
    input  logic              fl_valid,
    input  logic [SID_W-1:0]  fl_sid,
    input  logic [DID_W-1:0]  fl_did,
    input  logic [ADDR_W-1:0] fl_addr,
    input  logic [PTE_W-1:0]  fl_pte,
    input  logic              fl_rd,
    input  logic              fl_wr,
    input  logic              inv_valid,
    input  logic [1:0]        inv_kind,
    input  logic [DID_W-1:0]  inv_did,
    input  logic [ADDR_W-1:0] inv_addr,
    input  logic [AM_W-1:0]   inv_am,
    output logic              busy,
    output logic              inv_done,
    output logic              inv_err
);

    localparam int FRAME_W = ADDR_W - PAGE_SHIFT;
    localparam int KEY_W   = SID_SHIFT + SID_W;
    localparam int TAG_W   = (FRAME_W > KEY_W) ? FRAME_W : KEY_W;
    localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q   [ENTRIES];
    logic [FRAME_W-1:0] frame_q [ENTRIES];
    logic [DID_W-1:0]   did_q   [ENTRIES];
    logic [PTE_W-1:0]   pte_q   [ENTRIES];
    logic [ENTRIES-1:0] rd_q;
    logic [ENTRIES-1:0] wr_q;

    logic [FRAME_W-1:0] lk_frame, fl_frame, inv_frame;
    logic [TAG_W-1:0]   lk_tag, fl_tag;
    logic [ENTRIES-1:0] lk_vec, fl_vec, inv_vec;
    logic [IDX_W-1:0]   slot;
    logic               flush;
    logic               accept, clear_all, sweep_en;
    logic [IDX_W-1:0]   sweep_idx;
    logic               cmd_page;
    logic [DID_W-1:0]   cmd_did;
    logic [FRAME_W-1:0] cmd_frame, cmd_mask;
    logic               fill_go;
    logic [PTE_W-1:0]   sel_pte;
    logic               sel_rd, sel_wr;

    assign lk_frame  = lk_addr[ADDR_W-1:PAGE_SHIFT];
    assign fl_frame  = fl_addr[ADDR_W-1:PAGE_SHIFT];
    assign inv_frame = inv_addr[ADDR_W-1:PAGE_SHIFT];
    assign lk_tag    = TAG_W'(lk_frame) | (TAG_W'(lk_sid) << SID_SHIFT);
    assign fl_tag    = TAG_W'(fl_frame) | (TAG_W'(fl_sid) << SID_SHIFT);

    xlat_match #(
        .N(ENTRIES), .TAG_W(TAG_W), .FRAME_W(FRAME_W), .DID_W(DID_W)
    ) u_match (
        .valid_q  (valid_q),
        .tag_q    (tag_q),
        .frame_q  (frame_q),
        .did_q    (did_q),
        .lk_tag   (lk_tag),
        .fl_tag   (fl_tag),
        .cmd_page (cmd_page),
        .cmd_did  (cmd_did),
        .cmd_frame(cmd_frame),
        .cmd_mask (cmd_mask),
        .lk_vec   (lk_vec),
        .fl_vec   (fl_vec),
        .inv_vec  (inv_vec)
    );

    xlat_slot_pick #(.N(ENTRIES)) u_pick (
        .valid_q(valid_q),
        .fl_vec (fl_vec),
        .slot   (slot),
        .flush  (flush)
    );

    xlat_inv_ctrl #(
        .N(ENTRIES), .FRAME_W(FRAME_W), .DID_W(DID_W), .AM_W(AM_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .inv_valid(inv_valid),
        .inv_kind (inv_kind),
        .inv_did  (inv_did),
        .inv_frame(inv_frame),
        .inv_am   (inv_am),
        .busy     (busy),
        .done     (inv_done),
        .err      (inv_err),
        .accept   (accept),
        .clear_all(clear_all),
        .sweep_en (sweep_en),
        .sweep_idx(sweep_idx),
        .cmd_page (cmd_page),
        .cmd_did  (cmd_did),
        .cmd_frame(cmd_frame),
        .cmd_mask (cmd_mask)
    );

    // A fill is taken only when idle and no command arrives in the same cycle.
    assign fill_go = fl_valid && !busy && !inv_valid;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (clear_all) begin
            valid_q <= '0;
        end else if (sweep_en && inv_vec[sweep_idx]) begin
            valid_q[sweep_idx] <= 1'b0;
        end else if (fill_go) begin
            if (flush) begin
                valid_q <= '0;
            end
            valid_q[slot] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_go) begin
            tag_q[slot]   <= fl_tag;
            frame_q[slot] <= fl_frame;
            did_q[slot]   <= fl_did;
            pte_q[slot]   <= fl_pte;
            rd_q[slot]    <= fl_rd;
            wr_q[slot]    <= fl_wr;
        end
    end

    always_comb begin
        sel_pte = '0;
        sel_rd  = 1'b0;
        sel_wr  = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_vec[i]) begin
                sel_pte = sel_pte | pte_q[i];
                sel_rd  = sel_rd | rd_q[i];
                sel_wr  = sel_wr | wr_q[i];
            end
        end
    end

    always_comb begin
        lk_hit  = lk_valid && !busy && (|lk_vec);
        lk_pte  = lk_hit ? sel_pte : '0;
        lk_rd   = lk_hit && sel_rd;
        lk_wr   = lk_hit && sel_wr;
        lk_phys = lk_hit ? {sel_pte[ADDR_W-1:PAGE_SHIFT], lk_addr[PAGE_SHIFT-1:0]}
                         : '0;
    end

endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
    parameter int N    = 16,
    parameter int AM_W = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            inv_done,
    input logic            inv_err,
    input logic            lk_hit,
    input logic            inv_valid,
    input logic [1:0]      inv_kind,
    input logic [AM_W-1:0] inv_am,
    input logic [N-1:0]    valid_q,
    input logic [N-1:0]    lk_vec
);

    logic take, reject;
    assign take   = inv_valid && !busy;
    assign reject = take && ((inv_kind == 2'b00) ||
                             ((inv_kind == 2'b11) && (inv_am > AM_W'(9))));

    a_r10_busy_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !lk_hit);

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        inv_done |=> !inv_done);

    a_r4_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_vec));

    a_r6_global_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (take && inv_kind == 2'b01) |=> (valid_q == '0));

    a_r9_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        reject |=> (valid_q == $past(valid_q)));

    a_r9_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        inv_err |-> inv_done);

endmodule

bind xlat_cache xlat_cache_chk #(.N(ENTRIES), .AM_W(AM_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .inv_done (inv_done),
    .inv_err  (inv_err),
    .lk_hit   (lk_hit),
    .inv_valid(inv_valid),
    .inv_kind (inv_kind),
    .inv_am   (inv_am),
    .valid_q  (valid_q),
    .lk_vec   (lk_vec)
);

// File: tb/tb_xlat_cache.sv
`timescale 1ns/1ps
module tb_xlat_cache;

    localparam int NE = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 0;
    logic [15:0] lk_sid = 0;
    logic [47:0] lk_addr = 0;
    logic        lk_hit;
    logic [63:0] lk_pte;
    logic        lk_rd, lk_wr;
    logic [47:0] lk_phys;
    logic        fl_valid = 0;
    logic [15:0] fl_sid = 0, fl_did = 0;
    logic [47:0] fl_addr = 0;
    logic [63:0] fl_pte = 0;
    logic        fl_rd = 0, fl_wr = 0;
    logic        inv_valid = 0;
    logic [1:0]  inv_kind = 0;
    logic [15:0] inv_did = 0;
    logic [47:0] inv_addr = 0;
    logic [5:0]  inv_am = 0;
    logic        busy, inv_done, inv_err;

    always #2.5 clk = ~clk;

    xlat_cache #(.ENTRIES(NE)) dut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_sid(lk_sid), .lk_addr(lk_addr),
        .lk_hit(lk_hit), .lk_pte(lk_pte), .lk_rd(lk_rd), .lk_wr(lk_wr),
        .lk_phys(lk_phys),
        .fl_valid(fl_valid), .fl_sid(fl_sid), .fl_did(fl_did),
        .fl_addr(fl_addr), .fl_pte(fl_pte), .fl_rd(fl_rd), .fl_wr(fl_wr),
        .inv_valid(inv_valid), .inv_kind(inv_kind), .inv_did(inv_did),
        .inv_addr(inv_addr), .inv_am(inv_am),
        .busy(busy), .inv_done(inv_done), .inv_err(inv_err)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // reference contents
    bit          m_v   [NE];
    logic [15:0] m_sid [NE];
    logic [35:0] m_fr  [NE];
    logic [15:0] m_did [NE];
    logic [63:0] m_pte [NE];
    bit          m_rd  [NE];
    bit          m_wr  [NE];

    logic [15:0] p_sid [64];
    logic [35:0] p_fr  [64];
    int          np = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic void add_probe(input logic [15:0] s, input logic [35:0] f);
        if (np < 64) begin
            p_sid[np] = s;
            p_fr[np]  = f;
            np++;
        end
    endfunction

    function automatic void model_clear();
        for (int i = 0; i < NE; i++) m_v[i] = 0;
    endfunction

    function automatic void model_fill(input logic [15:0] s, input logic [35:0] f,
                                       input logic [15:0] d, input logic [63:0] p,
                                       input bit r, input bit w);
        int k = -1;
        int cnt = 0;
        for (int i = 0; i < NE; i++) begin
            if (m_v[i] && m_sid[i] == s && m_fr[i] == f && k < 0) k = i;
            if (m_v[i]) cnt++;
        end
        if (k < 0) begin
            if (cnt == NE) begin
                model_clear();
                k = 0;
            end else begin
                for (int i = NE - 1; i >= 0; i--) if (!m_v[i]) k = i;
            end
        end
        m_v[k] = 1; m_sid[k] = s; m_fr[k] = f; m_did[k] = d;
        m_pte[k] = p; m_rd[k] = r; m_wr[k] = w;
    endfunction

    task automatic lookup_cmp(input logic [15:0] s, input logic [35:0] f,
                              input logic [11:0] off, input string req);
        bit eh = 0;
        logic [63:0] ep = 0;
        bit er = 0, ew = 0;
        for (int i = 0; i < NE; i++) begin
            if (m_v[i] && m_sid[i] == s && m_fr[i] == f) begin
                eh = 1; ep = m_pte[i]; er = m_rd[i]; ew = m_wr[i];
            end
        end
        @(negedge clk);
        lk_valid = 1; lk_sid = s; lk_addr = {f, off};
        #1;
        chk(lk_hit == eh, req, "hit", 64'(lk_hit), 64'(eh));
        if (eh) begin
            chk(lk_pte == ep, req, "pte", lk_pte, ep);
            chk({lk_rd, lk_wr} == {er, ew}, req, "perm", 64'({lk_rd, lk_wr}), 64'({er, ew}));
            chk(lk_phys == {ep[47:12], off}, req, "phys", 64'(lk_phys), 64'({ep[47:12], off}));
        end
        lk_valid = 0;
    endtask

    task automatic check_probes(input string req);
        for (int k = 0; k < np; k++) lookup_cmp(p_sid[k], p_fr[k], 12'(12'h5A3 + k * 7), req);
    endtask

    task automatic do_fill(input logic [15:0] s, input logic [35:0] f,
                           input logic [15:0] d, input logic [63:0] p,
                           input bit r, input bit w);
        @(negedge clk);
        fl_valid = 1; fl_sid = s; fl_addr = {f, 12'h000}; fl_did = d;
        fl_pte = p; fl_rd = r; fl_wr = w;
        @(negedge clk);
        fl_valid = 0;
        model_fill(s, f, d, p, r, w);
        add_probe(s, f);
    endtask

    task automatic wait_done(output int n);
        n = 1;
        while (!inv_done && n < 100) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic do_inv(input logic [1:0] kind, input logic [15:0] d,
                          input logic [35:0] f, input logic [5:0] am,
                          input int exp_n, input bit exp_err, input string req);
        int n;
        @(negedge clk);
        inv_valid = 1; inv_kind = kind; inv_did = d;
        inv_addr = {f, 12'h3C1}; inv_am = am;
        @(negedge clk);
        inv_valid = 0;
        chk(busy == 1'b1, req, "busy after accept", 64'(busy), 64'd1);
        wait_done(n);
        chk(n == exp_n, req, "cycles to done", 64'(n), 64'(exp_n));
        chk(inv_err == exp_err, req, "err", 64'(inv_err), 64'(exp_err));
        @(negedge clk);
        chk(busy == 1'b0 && inv_done == 1'b0, req, "idle after done",
            64'({busy, inv_done}), 64'd0);
        if (!exp_err) begin
            for (int i = 0; i < NE; i++) begin
                if (kind == 2'b01) m_v[i] = 0;
                else if (kind == 2'b10 && m_did[i] == d) m_v[i] = 0;
                else if (kind == 2'b11 && m_did[i] == d && (m_fr[i] >> am) == (f >> am)) m_v[i] = 0;
            end
        end
    endtask

    function automatic logic [63:0] mk_pte(input int k);
        return 64'h8000_0000_0000_0000 | (64'(k) * 64'h0000_0013_5791_3000);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state
        @(negedge clk);
        chk(busy == 0 && inv_done == 0, "R1", "busy/done", 64'({busy, inv_done}), 64'd0);
        lookup_cmp(16'd1, 36'h100, 12'h010, "R1");
        lookup_cmp(16'd0, 36'h0, 12'h000, "R1");

        // R2, R3: basic hits, same frame under two source IDs
        np = 0;
        do_fill(16'd1, 36'h100, 16'd5, mk_pte(1), 1, 0);
        do_fill(16'd2, 36'h100, 16'd5, mk_pte(2), 0, 1);
        do_fill(16'd1, 36'h200, 16'd6, mk_pte(3), 1, 1);
        add_probe(16'd3, 36'h100);
        check_probes("R2");
        lookup_cmp(16'd2, 36'h100, 12'hFFF, "R3");
        lookup_cmp(16'd4, 36'h100, 12'h000, "R3");

        // R4: overwrite in place, then fill to exactly full
        do_fill(16'd1, 36'h100, 16'd5, mk_pte(9), 0, 1);
        do_fill(16'd4, 36'h300, 16'd6, mk_pte(4), 1, 0);
        check_probes("R4");

        // R5: overflow empties the cache
        do_fill(16'd5, 36'h400, 16'd6, mk_pte(5), 1, 1);
        check_probes("R5");

        // R11: command beats a simultaneous fill
        @(negedge clk);
        inv_valid = 1; inv_kind = 2'b01;
        fl_valid = 1; fl_sid = 16'd6; fl_addr = {36'h500, 12'h0}; fl_did = 16'd1;
        fl_pte = mk_pte(6);
        @(negedge clk);
        inv_valid = 0; fl_valid = 0;
        wait_done(n);
        chk(n == 1, "R11", "global cycles", 64'(n), 64'd1);
        @(negedge clk);
        model_clear();
        add_probe(16'd6, 36'h500);
        check_probes("R11");

        // R7: domain invalidate
        np = 0;
        do_fill(16'd1, 36'h10, 16'd7, mk_pte(11), 1, 0);
        do_fill(16'd2, 36'h20, 16'd8, mk_pte(12), 0, 1);
        do_fill(16'd3, 36'h30, 16'd7, mk_pte(13), 1, 1);
        do_fill(16'd4, 36'h40, 16'd9, mk_pte(14), 0, 0);
        do_inv(2'b10, 16'd7, 36'h0, 6'd0, NE + 1, 0, "R7");
        check_probes("R7");

        // R10: lookups, fills and commands ignored while busy
        np = 0;
        do_inv(2'b01, 16'd0, 36'h0, 6'd0, 1, 0, "R6");
        do_fill(16'd9, 36'h900, 16'd3, mk_pte(20), 1, 1);
        @(negedge clk);
        inv_valid = 1; inv_kind = 2'b10; inv_did = 16'd12;
        @(negedge clk);
        inv_valid = 0;
        @(negedge clk);
        lk_valid = 1; lk_sid = 16'd9; lk_addr = {36'h900, 12'h0};
        fl_valid = 1; fl_sid = 16'd10; fl_addr = {36'hA00, 12'h0}; fl_did = 16'd3;
        inv_valid = 1; inv_kind = 2'b01;
        #1;
        chk(lk_hit == 0, "R10", "hit while busy", 64'(lk_hit), 64'd0);
        @(negedge clk);
        lk_valid = 0; fl_valid = 0; inv_valid = 0;
        wait_done(n);
        @(negedge clk);
        add_probe(16'd10, 36'hA00);
        check_probes("R10");

        // R8: page invalidate over every mask value
        for (int am = 0; am <= 9; am++) begin
            logic [35:0] base;
            logic [35:0] grp;
            base = 36'h4_0000;
            grp  = 36'(1) << am;
            np = 0;
            do_inv(2'b01, 16'd0, 36'h0, 6'd0, 1, 0, "R6");
            do_fill(16'd1, base,            16'd21, mk_pte(30 + am), 1, 0);
            do_fill(16'd2, base + grp - 1,  16'd21, mk_pte(40 + am), 0, 1);
            do_fill(16'd3, base + grp,      16'd21, mk_pte(50 + am), 1, 1);
            do_fill(16'd4, base,            16'd22, mk_pte(60 + am), 1, 0);
            add_probe(16'd5, base - 1);
            do_inv(2'b11, 16'd21, base + (grp >> 1), 6'(am), NE + 1, 0, "R8");
            check_probes("R8");
        end

        // R9: rejected commands change nothing
        np = 0;
        do_inv(2'b01, 16'd0, 36'h0, 6'd0, 1, 0, "R6");
        do_fill(16'd1, 36'h7000, 16'd30, mk_pte(70), 1, 1);
        do_fill(16'd2, 36'h7001, 16'd30, mk_pte(71), 0, 1);
        do_inv(2'b11, 16'd30, 36'h7000, 6'd10, 1, 1, "R9");
        check_probes("R9");
        do_inv(2'b00, 16'd30, 36'h7000, 6'd0, 1, 1, "R9");
        check_probes("R9");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule